// File: doc/BRIEF.md
# Burst Start Address Auto-Latch Sequencer

This block sits on the device side of a synchronous burst-read memory. It picks up the first read address without any address command. The host releases the ready line high, and the block counts rising clock edges from that point. On the third edge it takes the address bus into a start-address register. On the fourth edge it marks the beginning of burst data.

While the sequence runs, the data bus carries an all-ones sync/dummy pattern. Outside the sequence, the data bus passes the word presented by the array on `rd_data`. A configuration bit turns the feature on. While that bit is set, pulling the ready line low in mid-sequence aborts the sequence.

The trigger rule depends on reset history. After the asynchronous power-on reset, either of two events can start the first sequence: a rising ready line or a falling output enable, whichever of the two comes last. Once one sequence has completed, only a rising ready line can start one.

The controller has three states:
- `ST_IDLE` waits for a trigger.
- `ST_SYNC` counts edges and drives dummy data.
- `ST_BURST` lasts one cycle and marks burst start.

It takes these transitions:
- `ST_IDLE`→`ST_SYNC` on a qualified trigger.
- `ST_SYNC`→`ST_SYNC` on each counted edge.
- `ST_SYNC`→`ST_IDLE` on abort.
- `ST_SYNC`→`ST_BURST` on the fourth edge.
- `ST_BURST`→`ST_IDLE` unconditionally.

Top module: `burst_start_latch`

## Requirements
- R1: While `por_n` is low and right after it is released: `start_addr` is 0, `burst_start` is 0, `data_out` equals `rd_data`, and the power-on trigger rule is in force.
- R2: A trigger starts a sequence only if, at the clock edge that detects it, `addr_strobe`=1, `pd_n`=1, `oe_n`=0 and `auto_latch_en`=1. Otherwise the block stays idle, the outputs do not change, and `start_addr` keeps its previous value.
- R3: Edge 1 is the first rising clock edge at which `ready_in` is sampled 1 after a sample of 0. Edges 2, 3 and 4 are the following rising edges.
- R4: `start_addr` loads the value that `addr` holds at edge 3.
- R5: `burst_start` is 1 for exactly the one clock cycle after edge 4. In that same cycle `data_out` returns to `rd_data`.
- R6: From edge 1 until edge 4, `data_out` is all ones (16'hFFFF).
- R7: If `ready_in` is sampled 0 during the sequence while `auto_latch_en`=1, the block goes idle at that edge and no `burst_start` pulse follows. `start_addr` changes only if edge 3 has already passed.
- R8: If `auto_latch_en` is 0, a low `ready_in` during the sequence has no effect, and the sequence completes normally.
- R9: Until the first sequence after power-on reset completes, two events can trigger: `ready_in` rising while `oe_n` is low, or `oe_n` falling while `ready_in` is high.
- R10: After one sequence has completed, an `oe_n` falling edge alone never starts a sequence. Only a `ready_in` rising edge does.
- R11: Only a completed sequence ends the power-on rule. Triggers that fail their conditions leave it in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock, rising edge active |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ready_in | input | 1 | Ready/wait line level driven by the host side |
| oe_n | input | 1 | Output enable, active low |
| addr_strobe | input | 1 | Address-valid strobe level; must be high to start |
| pd_n | input | 1 | Reset/power-down pin, active low; must be high to start |
| auto_latch_en | input | 1 | Configuration bit enabling the auto-latch feature |
| addr | input | 23 | Address bus |
| rd_data | input | 16 | Array read word passed to the data bus outside the sequence |
| start_addr | output | 23 | Latched first read address |
| data_out | output | 16 | Data bus: all ones during the sequence, else `rd_data` |
| burst_start | output | 1 | One-cycle mark of the first burst data cycle |

## Verification
The bench builds the block with the default parameters: a 23-bit address, a 16-bit data bus, capture on edge 3 and completion on edge 4. This is small enough to walk through all sixteen combinations of the four start-condition inputs. It also covers every abort position across edges 2 to 4, with the enable bit either held or cleared. The expected dummy window, pulse cycle and captured address are derived from edge arithmetic.

Two resets, each followed by a run of the sequence, cover both power-on trigger events. They also cover the change to the normal rule, and failed triggers that leave the power-on rule in place.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_BURST = 2'd2
    } bsl_state_t;

    // Bit positions of the sampled control lines inside the edge detector
    localparam int IDX_READY = 0;
    localparam int IDX_OE    = 1;
    localparam int N_LINES   = 2;

endpackage

// File: rtl/bsl_edge.sv
// Registered edge detector. Each bit reports either a rising or a falling
// transition, chosen per bit by RISE_MASK, against its sample from the
// previous clock edge.
module bsl_edge #(
    parameter int              W         = 2,
    parameter logic [W-1:0]    RISE_MASK = '1,
    parameter logic [W-1:0]    RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] hit
);

    logic [W-1:0] d_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            d_q <= RST_VAL;
        end else begin
            d_q <= d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RISE_MASK[i]) begin : g_rise
            assign hit[i] = d[i] & ~d_q[i];
        end else begin : g_fall
            assign hit[i] = ~d[i] & d_q[i];
        end
    end

endmodule

// File: rtl/bsl_trig.sv
// Start qualification: picks the trigger rule for the current mode and
// gates it with the level conditions that must all hold together.
module bsl_trig (
    input  logic por_mode,
    input  logic ready_lvl,
    input  logic ready_rise,
    input  logic oe_n,
    input  logic oe_fall,
    input  logic addr_strobe,
    input  logic pd_n,
    input  logic auto_latch_en,
    output logic fire
);

    logic levels_ok;
    logic event_seen;

    always_comb begin
        levels_ok = addr_strobe && pd_n && !oe_n && auto_latch_en;
        if (por_mode) begin
            // whichever of the two events comes last starts the sequence
            event_seen = (ready_rise && !oe_n) || (oe_fall && ready_lvl);
        end else begin
            event_seen = ready_rise;
        end
        fire = levels_ok && event_seen;
    end

endmodule

// File: rtl/bsl_fsm.sv
// Edge-counting controller: tracks the sequence, captures the address on
// the latch edge and ends the power-on trigger rule on completion.
module bsl_fsm
    import bsl_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int LATCH_EDGE  = 3,
    parameter int TOTAL_EDGES = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              fire,
    input  logic              ready_lvl,
    input  logic              auto_latch_en,
    input  logic [ADDR_W-1:0] addr,
    output bsl_state_t        state,
    output logic [ADDR_W-1:0] start_addr,
    output logic              por_mode
);

    localparam int CNT_W = $clog2(TOTAL_EDGES + 1);
    localparam logic [CNT_W-1:0] LATCH_CNT = CNT_W'(LATCH_EDGE);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(TOTAL_EDGES);
    localparam logic [CNT_W-1:0] FIRST_CNT = CNT_W'(1);

    bsl_state_t       state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cnt_inc;
    logic             capture;
    logic             complete;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            start_addr <= '0;
            por_mode   <= 1'b1;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (capture) begin
                start_addr <= addr;
            end
            if (complete) begin
                por_mode <= 1'b0;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        capture   = 1'b0;
        complete  = 1'b0;
        cnt_inc   = cnt + FIRST_CNT;
        unique case (state)
            ST_IDLE: begin
                if (fire) begin
                    state_nxt = ST_SYNC;
                    cnt_nxt   = FIRST_CNT;
                end
            end
            ST_SYNC: begin
                if (!ready_lvl && auto_latch_en) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt_inc;
                    if (cnt_inc == LATCH_CNT) begin
                        capture = 1'b1;
                    end
                    if (cnt_inc == LAST_CNT) begin
                        state_nxt = ST_BURST;
                        cnt_nxt   = '0;
                        complete  = 1'b1;
                    end
                end
            end
            ST_BURST: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

endmodule

// File: rtl/burst_start_latch.sv
module burst_start_latch
    import bsl_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int DATA_W      = 16,
    parameter int LATCH_EDGE  = 3,
    parameter int TOTAL_EDGES = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ready_in,
    input  logic              oe_n,
    input  logic              addr_strobe,
    input  logic              pd_n,
    input  logic              auto_latch_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] data_out,
    output logic              burst_start
);

    localparam logic [DATA_W-1:0] DUMMY_WORD = '1;
    // ready detects rising, output enable (active low) detects falling;
    // output enable resets to its inactive (high) value
    localparam logic [N_LINES-1:0] EDGE_RISE = N_LINES'(1) << IDX_READY;
    localparam logic [N_LINES-1:0] EDGE_RST  = N_LINES'(1) << IDX_OE;

    logic [N_LINES-1:0] lines;
    logic [N_LINES-1:0] edges;
    logic               fire;
    logic               por_mode;
    logic               in_seq;
    bsl_state_t         state;

    assign lines[IDX_READY] = ready_in;
    assign lines[IDX_OE]    = oe_n;

    bsl_edge #(
        .W         (N_LINES),
        .RISE_MASK (EDGE_RISE),
        .RST_VAL   (EDGE_RST)
    ) u_edge (
        .clk   (clk),
        .por_n (por_n),
        .d     (lines),
        .hit   (edges)
    );

    bsl_trig u_trig (
        .por_mode      (por_mode),
        .ready_lvl     (ready_in),
        .ready_rise    (edges[IDX_READY]),
        .oe_n          (oe_n),
        .oe_fall       (edges[IDX_OE]),
        .addr_strobe   (addr_strobe),
        .pd_n          (pd_n),
        .auto_latch_en (auto_latch_en),
        .fire          (fire)
    );

    bsl_fsm #(
        .ADDR_W      (ADDR_W),
        .LATCH_EDGE  (LATCH_EDGE),
        .TOTAL_EDGES (TOTAL_EDGES)
    ) u_fsm (
        .clk           (clk),
        .por_n         (por_n),
        .fire          (fire),
        .ready_lvl     (ready_in),
        .auto_latch_en (auto_latch_en),
        .addr          (addr),
        .state         (state),
        .start_addr    (start_addr),
        .por_mode      (por_mode)
    );

    // Output logic
    always_comb begin
        in_seq      = 1'b0;
        burst_start = 1'b0;
        data_out    = rd_data;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SYNC: begin
                in_seq   = 1'b1;
                data_out = DUMMY_WORD;
            end
            ST_BURST: begin
                burst_start = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/burst_start_latch_chk.sv
module burst_start_latch_chk #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic              ready_in,
    input logic              auto_latch_en,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] start_addr,
    input logic [DATA_W-1:0] data_out,
    input logic              burst_start,
    input logic              in_seq,
    input logic              por_mode
);

    // R5
    pulse_once_chk: assert property (@(posedge clk) disable iff (!por_n)
        burst_start |=> !burst_start);

    // R6
    dummy_lead_chk: assert property (@(posedge clk) disable iff (!por_n)
        burst_start |-> ($past(data_out) == {DATA_W{1'b1}}));

    // R4
    capture_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(start_addr) |-> (start_addr == $past(addr)));

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        (in_seq && !ready_in && auto_latch_en) |=> (!in_seq && !burst_start));

    // R11
    por_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        burst_start |-> !por_mode);

    // R10
    por_stays_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        !por_mode |=> !por_mode);

endmodule

bind burst_start_latch burst_start_latch_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_bsl_chk (
    .clk           (clk),
    .por_n         (por_n),
    .ready_in      (ready_in),
    .auto_latch_en (auto_latch_en),
    .addr          (addr),
    .start_addr    (start_addr),
    .data_out      (data_out),
    .burst_start   (burst_start),
    .in_seq        (in_seq),
    .por_mode      (por_mode)
);

// File: tb/test_burst_start_latch.sv
module test_burst_start_latch;

    localparam int AW = 23;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          ready_in = 1'b0;
    logic          oe_n = 1'b1;
    logic          addr_strobe = 1'b1;
    logic          pd_n = 1'b1;
    logic          auto_latch_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] rd_data = 16'h5A3C;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] data_out;
    logic          burst_start;

    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;
    logic [AW-1:0] model_addr = '0;

    always #10 clk = ~clk;

    burst_start_latch i_burst_start_latch (
        .clk           (clk),
        .por_n         (por_n),
        .ready_in      (ready_in),
        .oe_n          (oe_n),
        .addr_strobe   (addr_strobe),
        .pd_n          (pd_n),
        .auto_latch_en (auto_latch_en),
        .addr          (addr),
        .rd_data       (rd_data),
        .start_addr    (start_addr),
        .data_out      (data_out),
        .burst_start   (burst_start)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        por_n = 1'b0; ready_in = 1'b0; oe_n = 1'b1;
        addr_strobe = 1'b1; pd_n = 1'b1; auto_latch_en = 1'b1;
        #3;
        chk(32'(start_addr), 0, "R1", "start_addr in reset");
        chk(32'(burst_start), 0, "R1", "burst_start in reset");
        chk(32'(data_out), 32'(rd_data), "R1", "data_out in reset");
        @(negedge clk);
        por_n = 1'b1;
        model_addr = '0;
        @(negedge clk);
        chk(32'(start_addr), 0, "R1", "start_addr after release");
        chk(32'(data_out), 32'(rd_data), "R1", "data_out after release");
    endtask

    // trig 0: ready rises with oe_n already set; trig 1: oe_n falls with ready high
    task automatic seq(input int trig, input bit adv_v, input bit pd_v,
                       input bit oen_v, input bit cfg_v, input int abort_at,
                       input bit drop_cfg, input bit exp_go,
                       input logic [AW-1:0] base, input string req);
        bit in_s;
        bit pulse;
        bit aborted;
        bit captured;
        int ab_edge;
        @(negedge clk);
        addr_strobe = adv_v; pd_n = pd_v; auto_latch_en = cfg_v;
        if (trig == 0) begin
            oe_n = oen_v; ready_in = 1'b0;
        end else begin
            ready_in = 1'b1; oe_n = 1'b1;
        end
        repeat (2) @(negedge clk);
        if (trig == 0) ready_in = 1'b1;
        else oe_n = oen_v;
        aborted = exp_go && (abort_at > 0) && !drop_cfg;
        ab_edge = abort_at + 1;
        for (int k = 1; k <= 5; k++) begin
            addr = base + AW'(k);
            @(negedge clk);
            in_s  = exp_go && (k <= 3) && !(aborted && k >= ab_edge);
            pulse = exp_go && !aborted && (k == 4);
            chk(32'(data_out), in_s ? 32'hFFFF : 32'(rd_data), req,
                $sformatf("R6 data_out after edge %0d", k));
            chk(32'(burst_start), 32'(pulse), req,
                $sformatf("R5 burst_start after edge %0d", k));
            if (k == abort_at) ready_in = 1'b0;
            if (k == 1 && drop_cfg) auto_latch_en = 1'b0;
        end
        captured = exp_go && !(aborted && ab_edge <= 3);
        if (captured) model_addr = base + AW'(3);
        chk(32'(start_addr), 32'(model_addr), req, "R4 start_addr");
        ready_in = 1'b0; oe_n = 1'b1; auto_latch_en = 1'b1;
        addr_strobe = 1'b1; pd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        reset_check();
        // R9: output enable falling last, conditions fail first (R11 keeps rule)
        seq(1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 23'h100000, "R11");
        seq(1, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b1, 23'h200000, "R9");
        // R10: the same event no longer starts a sequence
        seq(1, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 23'h300000, "R10");
        seq(0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b1, 23'h400000, "R3");
        // R2: all sixteen level combinations
        for (int m = 0; m < 16; m++) begin
            seq(0, m[0], m[1], !m[2], m[3], 0, 1'b0, m == 15,
                23'h010000 * AW'(m + 1), "R2");
        end
        // R7 / R8: abort position sweep with enable held or cleared
        for (int d = 0; d < 2; d++) begin
            for (int a = 1; a <= 3; a++) begin
                seq(0, 1'b1, 1'b1, 1'b0, 1'b1, a, d[0], 1'b1,
                    23'h500000 + AW'(a * 64 + d * 16), d ? "R8" : "R7");
            end
        end
        // R9: ready rising last after a fresh power-on reset
        reset_check();
        seq(0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b1, 23'h7ABC00, "R9");
        seq(1, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 23'h600000, "R10");
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule